// File: doc/BRIEF.md
# Width-adaptive sum register bank

The block adds two unsigned 8-bit operands once per clock and keeps each result in the narrowest of four storage banks that can hold it. The banks are 1, 2, 4 and 8 bits wide. In the same cycle as the addition, a leading-one detector finds the highest set bit of the new sum. That position selects exactly one bank, and only that bank receives a write enable. The other banks keep their contents, as they would if they were asleep.

Every cycle the registered sum, the index of its highest set bit, the one-hot select of the bank written at that edge and the contents of all banks are visible at the outputs. A qualifier input gates the storage. While it is low the sum is still registered, but no bank is written and the select vector reads zero. The bank count is a parameter, and the operand width follows from it as the width of the largest bank.

Top module: `wsb_top`

## Requirements
- R1: At each rising edge `sum_q` takes the low 8 bits of `opnd_a + opnd_b`, whatever the value of `in_valid`.
- R2: `msb_idx` holds the bit position of the most significant 1 in the registered sum. For a sum of zero it reads 0.
- R3: When `in_valid` is high, the select bit k registered with the sum is the smallest k with 2^k > highest-one index. Highest-one index 0 (and a zero sum) gives k=0, index 1 gives k=1, indices 2-3 give k=2 and indices 4-7 give k=3. Bit k of `bank_sel` stands for the bank of width 2^k.
- R4: The selected bank k loads the low 2^k bits of the new sum, which are the whole sum.
- R5: At most one bit of `bank_sel` is set. Every bank whose select bit is clear keeps its previous contents across that edge.
- R6: When `in_valid` is low at an edge, `bank_sel` becomes all zeros and no bank changes.
- R7: Reset is synchronous and active high. It clears `sum_q`, `msb_idx`, `bank_sel` and all banks.
- R8: `bank_data` packs bank k (width 2^k) at bit offset 2^k-1: bank 0 at bit 0, bank 1 at bits 2:1, bank 2 at bits 6:3, bank 3 at bits 14:7.
- R9: A carry out of bit 7 is dropped. For example, 0xFF + 0x01 registers a sum of 0 and selects bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operands for storage |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| sum_q | output | 8 | Registered sum |
| msb_idx | output | 3 | Highest set bit index of `sum_q` |
| bank_sel | output | 4 | One-hot select of the bank written at the last edge |
| bank_data | output | 15 | Packed contents of all banks |

## Verification
The bench walks through each width threshold (sums 1, 2, 3, 4, 7, 8, 15, 16 and 255). A detector or decoder that is off by one at a power of two would write the wrong bank, or would truncate the sum in a bank that is too small. A zero sum and a wrapped carry (0xFF+0x01, 0x80+0x80) must both land in the 1-bit bank. A design that kept bit 8 would report the wrong sum, and one that treated zero specially would select nothing. A large sum presented with the qualifier low must leave every bank unchanged while `sum_q` still updates. A reset in the middle of a run must clear banks that were written earlier.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  // Position of the most significant 1 (0 when the vector is zero).
  function automatic int unsigned top_bit(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Smallest k with 2**k strictly greater than the highest-one index.
  function automatic int unsigned bank_for(input int unsigned idx);
    int unsigned r;
    r = 31;
    for (int k = 30; k >= 0; k--) begin
      if ((32'd1 << k) > idx) r = k;
    end
    return r;
  endfunction

  // Bit offset of bank k inside the packed contents vector.
  function automatic int unsigned bank_lo(input int unsigned k);
    return (32'd1 << k) - 32'd1;
  endfunction

endpackage

// File: rtl/wsb_adder.sv
module wsb_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {1'b0, b};
    sum  = full[W-1:0];
  end
endmodule

// File: rtl/wsb_lod.sv
module wsb_lod #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  v,
  output logic [IW-1:0] idx
);
  import wsb_pkg::*;
  always_comb idx = IW'(top_bit(32'(v)));
endmodule

// File: rtl/wsb_bank_sel.sv
module wsb_bank_sel #(
  parameter int NB = 4,
  parameter int IW = 3
) (
  input  logic          valid,
  input  logic [IW-1:0] idx,
  output logic [NB-1:0] sel
);
  import wsb_pkg::*;
  int unsigned k;
  always_comb begin
    k   = bank_for(32'(idx));
    sel = valid ? (NB'(1) << k) : '0;
  end
endmodule

// File: rtl/wsb_bank.sv
module wsb_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/wsb_top.sv
module wsb_top #(
  parameter int NB = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [(1<<(NB-1))-1:0]    opnd_a,
  input  logic [(1<<(NB-1))-1:0]    opnd_b,
  output logic [(1<<(NB-1))-1:0]    sum_q,
  output logic [$clog2(1<<(NB-1))-1:0] msb_idx,
  output logic [NB-1:0]             bank_sel,
  output logic [(1<<NB)-2:0]        bank_data
);
  localparam int SUM_W = 1 << (NB - 1);
  localparam int IW    = $clog2(SUM_W);

  // Named internal events, observed by the bound checker
  logic [SUM_W-1:0] sum_n;
  logic [IW-1:0]    idx_n;
  logic [NB-1:0]    sel_n;

  wsb_adder #(.W(SUM_W)) u_add (
    .a(opnd_a), .b(opnd_b), .sum(sum_n)
  );

  wsb_lod #(.W(SUM_W), .IW(IW)) u_lod (
    .v(sum_n), .idx(idx_n)
  );

  wsb_bank_sel #(.NB(NB), .IW(IW)) u_sel (
    .valid(in_valid), .idx(idx_n), .sel(sel_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      msb_idx  <= '0;
      bank_sel <= '0;
    end else begin
      sum_q    <= sum_n;
      msb_idx  <= idx_n;
      bank_sel <= sel_n;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_bank
    localparam int BW = 1 << k;
    localparam int LO = BW - 1;
    wsb_bank #(.W(BW)) u_bank (
      .clk(clk),
      .rst(rst),
      .we(sel_n[k]),
      .d(sum_n[BW-1:0]),
      .q(bank_data[LO +: BW])
    );
  end
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int NB = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [(1<<(NB-1))-1:0]      opnd_a,
  input logic [(1<<(NB-1))-1:0]      opnd_b,
  input logic [(1<<(NB-1))-1:0]      sum_q,
  input logic [$clog2(1<<(NB-1))-1:0] msb_idx,
  input logic [NB-1:0]               bank_sel,
  input logic [(1<<NB)-2:0]          bank_data,
  input logic [(1<<(NB-1))-1:0]      sum_n
);
  localparam int SUM_W = 1 << (NB - 1);

  // R1 / R9: registered sum is the wrapped sum of last cycle's operands
  assert_sum_wraps_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> sum_q == SUM_W'($past(opnd_a) + $past(opnd_b)));

  // R2: no 1 above msb_idx, and a 1 at msb_idx unless the sum is zero
  assert_msb_position_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((sum_q >> msb_idx) <= 1) && (sum_q == 0 || sum_q[msb_idx]));

  // R5: never more than one bank selected
  assert_sel_onehot0_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_sel));

  // R3: a qualified cycle always writes exactly one bank
  assert_valid_selects_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid) |-> $onehot(bank_sel));

  // R6: an unqualified cycle writes nothing
  assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !in_valid) |-> bank_sel == '0 && $stable(bank_data));

  // R1: the pre-register sum becomes the registered sum
  assert_sum_pipeline_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> sum_q == $past(sum_n));

  for (genvar k = 0; k < NB; k++) begin : g_chk
    localparam int BW = 1 << k;
    localparam int LO = BW - 1;
    // R4: selected bank holds the whole sum, which fits in it
    assert_bank_fits_R4: assert property (@(posedge clk) disable iff (rst)
      bank_sel[k] |-> (SUM_W'(bank_data[LO +: BW]) == sum_q));
    // R5: banks not selected keep their value
    assert_bank_holds_R5: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) && !bank_sel[k] |-> $stable(bank_data[LO +: BW]));
  end
endmodule

bind wsb_top wsb_checker #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .opnd_a(opnd_a), .opnd_b(opnd_b),
  .sum_q(sum_q), .msb_idx(msb_idx), .bank_sel(bank_sel),
  .bank_data(bank_data), .sum_n(sum_n)
);

// File: tb/sim_wsb_top.sv
module sim_wsb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opnd_a = '0;
  logic [7:0]  opnd_b = '0;
  logic [7:0]  sum_q;
  logic [2:0]  msb_idx;
  logic [3:0]  bank_sel;
  logic [14:0] bank_data;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  logic [7:0]  m_bank [4];
  logic [7:0]  m_sum;
  logic [2:0]  m_idx;
  logic [3:0]  m_sel;

  always #10 clk = ~clk; // 50 MHz

  wsb_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sum_q(sum_q), .msb_idx(msb_idx), .bank_sel(bank_sel),
    .bank_data(bank_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] pack_model();
    logic [14:0] f;
    f = '0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < (1 << k); j++)
        f[(1 << k) - 1 + j] = m_bank[k][j];
    return f;
  endfunction

  task automatic compare_all(input string tag);
    check(sum_q == m_sum, {tag, " R1 R9 sum"}, sum_q, m_sum);
    check(msb_idx == m_idx, {tag, " R2 msb index"}, msb_idx, m_idx);
    check(bank_sel == m_sel, {tag, " R3 R6 select"}, bank_sel, m_sel);
    check(bank_data == pack_model(), {tag, " R4 R5 R8 banks"}, bank_data, pack_model());
  endtask

  // Drive at a negedge, let one rising edge pass, compare at the next negedge
  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic v, input string tag);
    logic [8:0] wide;
    int hi, k;
    opnd_a = a; opnd_b = b; in_valid = v;
    wide = {1'b0, a} + {1'b0, b};
    m_sum = wide[7:0];
    hi = 0;
    for (int i = 7; i >= 0; i--) if (m_sum[i] && hi == 0 && i > 0) hi = i;
    m_idx = 3'(hi);
    k = 0;
    while ((1 << k) <= hi) k++;
    if (v) begin
      m_sel = 4'(1 << k);
      m_bank[k] = m_sum;
    end else begin
      m_sel = '0;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    opnd_a = 8'hAA; opnd_b = 8'h11; in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) m_bank[k] = '0;
    m_sum = '0; m_idx = '0; m_sel = '0;
    compare_all({tag, " R7 reset"});
  endtask

  task automatic t_doc_values();
    step(8'h00, 8'h7F, 1'b1, "doc 0+7F");
    step(8'h03, 8'h03, 1'b1, "doc 3+3");
  endtask

  task automatic t_thresholds();
    step(8'h00, 8'h00, 1'b1, "zero");
    step(8'h01, 8'h00, 1'b1, "sum1");
    step(8'h01, 8'h01, 1'b1, "sum2");
    step(8'h02, 8'h01, 1'b1, "sum3");
    step(8'h02, 8'h02, 1'b1, "sum4");
    step(8'h04, 8'h03, 1'b1, "sum7");
    step(8'h04, 8'h04, 1'b1, "sum8");
    step(8'h08, 8'h07, 1'b1, "sum15");
    step(8'h08, 8'h08, 1'b1, "sum16");
    step(8'hF0, 8'h0F, 1'b1, "sum255");
  endtask

  task automatic t_carry();
    step(8'hFF, 8'h01, 1'b1, "carry FF+01");
    step(8'h80, 8'h80, 1'b1, "carry 80+80");
    step(8'hC0, 8'h50, 1'b1, "carry C0+50");
  endtask

  task automatic t_idle();
    step(8'h05, 8'h06, 1'b1, "before idle");
    step(8'h70, 8'h0F, 1'b0, "idle big");
    step(8'h00, 8'h00, 1'b0, "idle zero");
    step(8'h01, 8'h01, 1'b1, "after idle");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m_bank[k] = '0;
    @(negedge clk);
    do_reset("start");
    t_doc_values();
    t_thresholds();
    t_carry();
    t_idle();
    do_reset("midrun");
    step(8'h00, 8'h01, 1'b1, "post reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule